// File: doc/BRIEF.md
# Single-Cycle RV32I Subset Processor Core

This core executes a subset of the 32-bit RISC-V base integer instruction set, and it finishes each instruction in a single clock. Within one cycle it fetches from a word-organised instruction array, decodes the instruction, reads two source registers, runs the ALU and the branch comparator, and picks the next program counter. At the rising edge that ends the cycle it commits the register write and any data-memory store. The supported instructions are register and immediate arithmetic and logic, signed set-less-than, word load and store, the four signed conditional branches, and the two jump-and-link forms.

While reset is held low, a simple write port fills the instruction array with a program. After reset is released the core runs that program from address 0. A combinational register read port lets the surrounding logic inspect the architectural registers, and the current program counter is exposed as an output.

Top module: `rvs_core`

## Requirements
- R1: The standard RV32I encodings are decoded. Opcode 0110011 gives add (funct3 000, funct7 0000000), sub (funct3 000, funct7 0100000), and (111), or (110) and slt (010), each with funct7 0000000. Opcode 0010011 gives addi (000), andi (111), ori (110) and slti (010). Opcode 0000011 with funct3 010 is lw. Opcode 0100011 with funct3 010 is sw. Opcode 1100011 gives beq (000), bne (001), blt (100) and bge (101). Opcode 1101111 is jal. Opcode 1100111 with funct3 000 is jalr.
- R2: Reset is synchronous and active low. It clears the PC to 0, every register and every data-memory word. The instruction array accepts writes only while reset is low.
- R3: add, addi, sub, and, andi, or and ori produce the 32-bit two's-complement result. slt and slti write 1 when rs1 is signed-less-than the second operand, and 0 otherwise. All immediates are sign-extended.
- R4: A write whose destination is x0 is discarded, so x0 always reads as zero.
- R5: lw and sw use rs1 plus the sign-extended immediate as the address, with the I-type immediate for lw and the S-type immediate for sw. The word index is the address with bits 1:0 dropped.
- R6: beq, bne, blt and bge branch on equal, not equal, signed less-than and signed greater-or-equal. A taken branch sets the next PC to PC plus the B-type offset. A branch that is not taken sets it to PC+4.
- R7: jal writes PC+4 to rd and sets the next PC to PC plus the J-type offset.
- R8: jalr writes PC+4 to rd and sets the next PC to the old rs1 value plus the I-type immediate. This holds even when rd equals rs1.
- R9: An encoding outside R1 writes no register and no memory, and it advances the PC by 4.
- R10: The core completes one instruction per clock. Its effects appear after the rising edge that ends the instruction, and the PC advances on that same edge.
- R11: The debug read port returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| imemWe | input | 1 | Instruction array write strobe (honoured only in reset) |
| imemAddr | input | $clog2(IMEM_DEPTH) | Instruction word index to write |
| imemWdata | input | 32 | Instruction word to write |
| dbgAddr | input | 5 | Register index to inspect |
| dbgData | output | XLEN | Contents of the inspected register |
| pcOut | output | XLEN | Current program counter |

## Verification
Each instruction's register or memory effect is committed at the rising edge that ends its cycle. The PC is therefore due one edge after release from reset and one edge after each instruction after that. The bench drives and samples on falling edges. It checks the PC on the first cycles after reset release. For whole programs it waits a number of cycles well beyond the instruction count, and by then the program has parked on a jump-to-self. Only then does it read registers through the combinational debug port, so every result has settled and stays stable.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  localparam logic [6:0] OP_R     = 7'b0110011;
  localparam logic [6:0] OP_IMM   = 7'b0010011;
  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_BR    = 7'b1100011;
  localparam logic [6:0] OP_JAL   = 7'b1101111;
  localparam logic [6:0] OP_JALR  = 7'b1100111;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} aluOp_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wbSel_e;
  typedef enum logic [1:0] {IMM_I, IMM_S, IMM_B, IMM_J} immSel_e;
  typedef enum logic [1:0] {BR_EQ, BR_NE, BR_LT, BR_GE} brCond_e;

  typedef struct packed {
    logic    regWe;
    logic    memWe;
    logic    useImm;
    logic    isBranch;
    logic    isJal;
    logic    isJalr;
    aluOp_e  aluOp;
    wbSel_e  wbSel;
    immSel_e immSel;
    brCond_e brCond;
  } ctrl_t;
endpackage

// File: rtl/rvs_control.sv
module rvs_control
  import rvs_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [6:0] funct7;
  logic       legal;
  ctrl_t      dec;

  assign opcode = instr[6:0];
  assign funct3 = instr[14:12];
  assign funct7 = instr[31:25];

  always_comb begin
    dec    = '0;
    legal  = 1'b0;
    dec.aluOp  = ALU_ADD;
    dec.wbSel  = WB_ALU;
    dec.immSel = IMM_I;
    dec.brCond = BR_EQ;
    case (opcode)
      OP_R: begin
        dec.regWe = 1'b1;
        if (funct7 == 7'b0000000) begin
          legal = 1'b1;
          case (funct3)
            3'b000:  dec.aluOp = ALU_ADD;
            3'b111:  dec.aluOp = ALU_AND;
            3'b110:  dec.aluOp = ALU_OR;
            3'b010:  dec.aluOp = ALU_SLT;
            default: legal = 1'b0;
          endcase
        end else if (funct7 == 7'b0100000 && funct3 == 3'b000) begin
          legal     = 1'b1;
          dec.aluOp = ALU_SUB;
        end
      end
      OP_IMM: begin
        dec.regWe  = 1'b1;
        dec.useImm = 1'b1;
        legal      = 1'b1;
        case (funct3)
          3'b000:  dec.aluOp = ALU_ADD;
          3'b111:  dec.aluOp = ALU_AND;
          3'b110:  dec.aluOp = ALU_OR;
          3'b010:  dec.aluOp = ALU_SLT;
          default: legal = 1'b0;
        endcase
      end
      OP_LOAD: begin
        legal      = (funct3 == 3'b010);
        dec.regWe  = 1'b1;
        dec.useImm = 1'b1;
        dec.wbSel  = WB_MEM;
      end
      OP_STORE: begin
        legal      = (funct3 == 3'b010);
        dec.memWe  = 1'b1;
        dec.useImm = 1'b1;
        dec.immSel = IMM_S;
      end
      OP_BR: begin
        dec.isBranch = 1'b1;
        dec.immSel   = IMM_B;
        legal        = 1'b1;
        case (funct3)
          3'b000:  dec.brCond = BR_EQ;
          3'b001:  dec.brCond = BR_NE;
          3'b100:  dec.brCond = BR_LT;
          3'b101:  dec.brCond = BR_GE;
          default: legal = 1'b0;
        endcase
      end
      OP_JAL: begin
        legal      = 1'b1;
        dec.isJal  = 1'b1;
        dec.regWe  = 1'b1;
        dec.wbSel  = WB_LINK;
        dec.immSel = IMM_J;
      end
      OP_JALR: begin
        legal      = (funct3 == 3'b000);
        dec.isJalr = 1'b1;
        dec.regWe  = 1'b1;
        dec.wbSel  = WB_LINK;
      end
      default: legal = 1'b0;
    endcase
  end

  // Unsupported encodings collapse to a strobe-free bundle: PC+4 only
  assign ctrl = legal ? dec : ctrl_t'('0);
endmodule

// File: rtl/rvs_regfile.sv
module rvs_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [RAW-1:0]  rs1Addr,
  input  logic [RAW-1:0]  rs2Addr,
  input  logic [RAW-1:0]  dbgAddr,
  output logic [XLEN-1:0] rs1Data,
  output logic [XLEN-1:0] rs2Data,
  output logic [XLEN-1:0] dbgData,
  input  logic            we,
  input  logic [RAW-1:0]  wAddr,
  input  logic [XLEN-1:0] wData
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wAddr != '0) begin
      regs[wAddr] <= wData;
    end
  end

  assign rs1Data = regs[rs1Addr];
  assign rs2Data = regs[rs2Addr];
  assign dbgData = regs[dbgAddr];

  AST_X0_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dbgAddr == '0) |-> (dbgData == '0)); // R4
endmodule

// File: rtl/rvs_datapath.sv
module rvs_datapath
  import rvs_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_DEPTH = 256,
  parameter int DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  output logic [31:0]     instr,
  input  logic            imemWe,
  input  logic [IAW-1:0]  imemAddr,
  input  logic [31:0]     imemWdata,
  input  logic [4:0]      dbgAddr,
  output logic [XLEN-1:0] dbgData,
  output logic [XLEN-1:0] pcOut
);
  logic [XLEN-1:0] pcQ, pcNext, pcPlus4;
  logic [31:0]     imem [IMEM_DEPTH];
  logic [XLEN-1:0] dmem [DMEM_DEPTH];
  logic [XLEN-1:0] rs1Data, rs2Data, immVal, aluB, aluRes, memRd, wbData;
  logic            brTaken, isEq, isLt;
  logic [DAW-1:0]  dIdx;

  // Program load port, live only while the core is held in reset
  always_ff @(posedge clk) begin
    if (!rstN && imemWe) imem[imemAddr] <= imemWdata;
  end

  assign instr   = imem[pcQ[IAW+1:2]];
  assign pcPlus4 = pcQ + XLEN'(4);

  always_comb begin
    case (ctrl.immSel)
      IMM_S:   immVal = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
      IMM_B:   immVal = {{(XLEN-13){instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
      IMM_J:   immVal = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
      default: immVal = {{(XLEN-12){instr[31]}}, instr[31:20]};
    endcase
  end

  rvs_regfile #(.XLEN(XLEN), .NREG(32)) regfile_i (
    .clk(clk), .rstN(rstN),
    .rs1Addr(instr[19:15]), .rs2Addr(instr[24:20]), .dbgAddr(dbgAddr),
    .rs1Data(rs1Data), .rs2Data(rs2Data), .dbgData(dbgData),
    .we(ctrl.regWe), .wAddr(instr[11:7]), .wData(wbData)
  );

  assign aluB = ctrl.useImm ? immVal : rs2Data;
  always_comb begin
    case (ctrl.aluOp)
      ALU_SUB: aluRes = rs1Data - aluB;
      ALU_AND: aluRes = rs1Data & aluB;
      ALU_OR:  aluRes = rs1Data | aluB;
      ALU_SLT: aluRes = XLEN'($signed(rs1Data) < $signed(aluB));
      default: aluRes = rs1Data + aluB;
    endcase
  end

  assign isEq = (rs1Data == rs2Data);
  assign isLt = ($signed(rs1Data) < $signed(rs2Data));
  always_comb begin
    case (ctrl.brCond)
      BR_NE:   brTaken = !isEq;
      BR_LT:   brTaken = isLt;
      BR_GE:   brTaken = !isLt;
      default: brTaken = isEq;
    endcase
  end

  // Jump target uses rs1 read this cycle, before the link write commits
  always_comb begin
    if (ctrl.isJal || (ctrl.isBranch && brTaken)) pcNext = pcQ + immVal;
    else if (ctrl.isJalr)                         pcNext = rs1Data + immVal;
    else                                          pcNext = pcPlus4;
  end

  assign dIdx  = aluRes[DAW+1:2];
  assign memRd = dmem[dIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DMEM_DEPTH; i++) dmem[i] <= '0;
    end else if (ctrl.memWe) begin
      dmem[dIdx] <= rs2Data;
    end
  end

  always_comb begin
    case (ctrl.wbSel)
      WB_MEM:  wbData = memRd;
      WB_LINK: wbData = pcPlus4;
      default: wbData = aluRes;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcNext;
  end

  assign pcOut = pcQ;

  AST_RESET_PC: assert property (@(posedge clk)
    !rstN |=> (pcQ == '0)); // R2
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.isJal || ctrl.isJalr || ctrl.isBranch) |=> (pcQ == $past(pcQ) + XLEN'(4))); // R9
  AST_BR_FALLTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.isBranch && !brTaken) |=> (pcQ == $past(pcQ) + XLEN'(4))); // R6
  AST_JAL_TGT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.isJal |=> (pcQ == $past(pcQ + immVal))); // R7
  AST_JALR_TGT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.isJalr |=> (pcQ == $past(rs1Data + immVal))); // R8
endmodule

// File: rtl/rvs_core.sv
module rvs_core
  import rvs_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_DEPTH = 256,
  parameter int DMEM_DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          imemWe,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imemAddr,
  input  logic [31:0]                   imemWdata,
  input  logic [4:0]                    dbgAddr,
  output logic [XLEN-1:0]               dbgData,
  output logic [XLEN-1:0]               pcOut
);
  ctrl_t       ctrl;
  logic [31:0] instr;

  rvs_control control_i (.instr(instr), .ctrl(ctrl));

  rvs_datapath #(.XLEN(XLEN), .IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) datapath_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .instr(instr),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemWdata(imemWdata),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .pcOut(pcOut)
  );
endmodule

// File: tb/rvs_core_tb.sv
`timescale 1ns/1ps
module rvs_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        imemWe = 1'b0;
  logic [7:0]  imemAddr = '0;
  logic [31:0] imemWdata = '0;
  logic [4:0]  dbgAddr = '0;
  logic [31:0] dbgData, pcOut;
  int nRun = 0, nFail = 0;
  logic [31:0] model [32];
  int wp;

  always #2.5 clk = ~clk;

  rvs_core dut_i (.clk(clk), .rstN(rstN), .imemWe(imemWe), .imemAddr(imemAddr),
    .imemWdata(imemWdata), .dbgAddr(dbgAddr), .dbgData(dbgData), .pcOut(pcOut));

  function automatic logic [31:0] encR(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] encI(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] encS(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] encB(logic [12:0] imm, logic [4:0] rs2, logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] encJ(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] sx12(logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction
  // Reference result for the nine arithmetic/logic forms (0..4 register, 5..8 immediate)
  function automatic logic [31:0] refAlu(int kind, logic [31:0] a, logic [31:0] b);
    case (kind % 5)
      0: return a + b;
      1: return (kind == 1) ? a - b : a & b;
      2: return a | b;
      3: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a & b;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask
  task automatic putWord(logic [31:0] w);
    @(negedge clk); imemWe = 1'b1; imemAddr = wp[7:0]; imemWdata = w;
    @(posedge clk); #0.5 imemWe = 1'b0;
    wp++;
  endtask
  task automatic readReg(int idx, output logic [31:0] v);
    @(negedge clk); dbgAddr = idx[4:0]; #0.5 v = dbgData;
  endtask
  task automatic holdReset();
    @(negedge clk); rstN = 1'b0; @(negedge clk); wp = 0;
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seedSink;
    seedSink = $urandom(7321);
    // ---------- Random arithmetic program ----------
    holdReset();
    chk("R2 pc in reset", pcOut, 32'd0);
    model[0] = 0;
    for (int i = 1; i < 32; i++) begin
      logic [11:0] imm;
      imm = 12'($urandom);
      putWord(encI(imm, 5'd0, 3'b000, 5'(i), 7'b0010011));
      model[i] = sx12(imm);
    end
    for (int k = 0; k < 40; k++) begin
      int kind;
      logic [4:0] rd, rs1, rs2;
      logic [11:0] imm;
      logic [31:0] res;
      kind = int'($urandom % 9);
      rd = 5'($urandom); rs1 = 5'($urandom); rs2 = 5'($urandom); imm = 12'($urandom);
      if (k < 4) begin imm = (k % 2 == 0) ? 12'h800 : 12'h7ff; kind = 5 + k; end
      case (kind)
        0: putWord(encR(7'h00, rs2, rs1, 3'b000, rd));
        1: putWord(encR(7'h20, rs2, rs1, 3'b000, rd));
        2: putWord(encR(7'h00, rs2, rs1, 3'b110, rd));
        3: putWord(encR(7'h00, rs2, rs1, 3'b010, rd));
        4: putWord(encR(7'h00, rs2, rs1, 3'b111, rd));
        5: putWord(encI(imm, rs1, 3'b000, rd, 7'b0010011));
        6: putWord(encI(imm, rs1, 3'b111, rd, 7'b0010011));
        7: putWord(encI(imm, rs1, 3'b110, rd, 7'b0010011));
        default: putWord(encI(imm, rs1, 3'b010, rd, 7'b0010011));
      endcase
      case (kind)
        5: res = model[rs1] + sx12(imm);
        6: res = model[rs1] & sx12(imm);
        7: res = model[rs1] | sx12(imm);
        8: res = refAlu(3, model[rs1], sx12(imm));
        default: res = refAlu(kind, model[rs1], model[rs2]);
      endcase
      if (rd != 0) model[rd] = res;
    end
    putWord(encJ(21'd0, 5'd0));
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); chk("R10 pc after first edge", pcOut, 32'd4);
    @(negedge clk); chk("R10 pc after second edge", pcOut, 32'd8);
    repeat (wp + 10) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      readReg(i, v);
      chk((i == 0) ? "R4 x0" : "R3 R11 random alu reg", v, model[i]);
    end
    // ---------- Directed control-flow and memory program ----------
    holdReset();
    putWord(encI(12'd5, 5'd0, 3'b000, 5'd1, 7'b0010011));       // 0  x1=5
    putWord(encI(12'hffd, 5'd0, 3'b000, 5'd2, 7'b0010011));     // 4  x2=-3
    putWord(encB(13'd8, 5'd1, 5'd2, 3'b100));                    // 8  blt taken
    putWord(encI(12'd1, 5'd0, 3'b000, 5'd10, 7'b0010011));      // 12 skipped
    putWord(encB(13'd8, 5'd1, 5'd2, 3'b101));                    // 16 bge not taken
    putWord(encI(12'd2, 5'd0, 3'b000, 5'd11, 7'b0010011));      // 20
    putWord(encB(13'd8, 5'd1, 5'd1, 3'b001));                    // 24 bne not taken
    putWord(encI(12'd3, 5'd0, 3'b000, 5'd12, 7'b0010011));      // 28
    putWord(encB(13'd8, 5'd1, 5'd1, 3'b000));                    // 32 beq taken
    putWord(encI(12'd4, 5'd0, 3'b000, 5'd13, 7'b0010011));      // 36 skipped
    putWord(encB(13'd8, 5'd2, 5'd1, 3'b101));                    // 40 bge taken
    putWord(encI(12'd5, 5'd0, 3'b000, 5'd14, 7'b0010011));      // 44 skipped
    putWord(encJ(21'd12, 5'd5));                                 // 48 jal x5 -> 60
    putWord(encI(12'd6, 5'd0, 3'b000, 5'd15, 7'b0010011));      // 52 skipped
    putWord(encI(12'd7, 5'd0, 3'b000, 5'd16, 7'b0010011));      // 56 skipped
    putWord(encI(12'd76, 5'd0, 3'b000, 5'd6, 7'b0010011));      // 60 x6=76
    putWord(encI(12'd4, 5'd6, 3'b000, 5'd6, 7'b1100111));       // 64 jalr x6,4(x6) -> 80
    putWord(encI(12'd8, 5'd0, 3'b000, 5'd17, 7'b0010011));      // 68 skipped
    putWord(encI(12'd8, 5'd0, 3'b000, 5'd17, 7'b0010011));      // 72 skipped
    putWord(encI(12'd8, 5'd0, 3'b000, 5'd17, 7'b0010011));      // 76 skipped
    putWord(encS(12'd7, 5'd2, 5'd1));                            // 80 sw x2 -> addr 12
    putWord(encI(12'd12, 5'd0, 3'b010, 5'd7, 7'b0000011));      // 84 lw x7 <- addr 12
    putWord(encI(12'd99, 5'd0, 3'b000, 5'd0, 7'b0010011));      // 88 addi x0 (dropped)
    putWord(32'h0000007F);                                       // 92 unknown opcode
    putWord(encR(7'h01, 5'd1, 5'd1, 3'b000, 5'd18));             // 96 bad funct7
    putWord(encR(7'h00, 5'd1, 5'd0, 3'b000, 5'd8));              // 100 x8 = x0 + x1
    putWord(encJ(21'd0, 5'd0));                                  // 104 park
    @(negedge clk); rstN = 1'b1;
    repeat (60) @(negedge clk);
    readReg(10, v); chk("R6 blt taken skip", v, 32'd0);
    readReg(11, v); chk("R6 bge fallthrough", v, 32'd2);
    readReg(12, v); chk("R6 bne fallthrough", v, 32'd3);
    readReg(13, v); chk("R6 beq taken skip", v, 32'd0);
    readReg(14, v); chk("R6 bge taken skip", v, 32'd0);
    readReg(5, v);  chk("R7 jal link", v, 32'd52);
    readReg(15, v); chk("R7 jal skip", v, 32'd0);
    readReg(16, v); chk("R7 jal skip", v, 32'd0);
    readReg(6, v);  chk("R8 jalr link rd==rs1", v, 32'd68);
    readReg(17, v); chk("R8 jalr old rs1 target", v, 32'd0);
    readReg(7, v);  chk("R5 sw/lw word", v, 32'hfffffffd);
    readReg(0, v);  chk("R4 x0 write dropped", v, 32'd0);
    readReg(18, v); chk("R9 bad funct7 no write", v, 32'd0);
    readReg(8, v);  chk("R9 R1 continue after illegal", v, 32'd5);
    chk("R9 pc parked", pcOut, 32'd104);
    // ---------- Reset clears state ----------
    holdReset();
    chk("R2 pc cleared", pcOut, 32'd0);
    readReg(1, v); chk("R2 reg cleared", v, 32'd0);
    putWord(encI(12'd12, 5'd0, 3'b010, 5'd3, 7'b0000011));
    putWord(encJ(21'd0, 5'd0));
    @(negedge clk); rstN = 1'b1;
    repeat (10) @(negedge clk);
    readReg(3, v); chk("R2 dmem cleared", v, 32'd0);
    chk("R7 self jump holds pc", pcOut, 32'd4);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule